// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small processor stops and how deeply it sleeps. When the processor runs its sleep instruction, the block halts the CPU and picks one of two depths from a standby-select bit it holds. In light sleep the peripherals and the external clock output keep running. In deep standby every clock is gated and a chosen set of peripherals gets a one-cycle initialization pulse. The CPU's own state is never cleared in either depth. A two-bit status output tells the board which state the chip is in, and memory refresh overrides that encoding while it runs.

Any interrupt request ends either depth. The interrupt block mask plays no part in wake-up, so the block has no mask input. The lowest-numbered pending source wins, and its event code is loaded into a visible event register. After standby, the clocks restart first and the CPU stays halted for a fixed settle count. A power-on reset (`rst`) or a manual reset (`mrst_i`) returns the block to the run state at once and clears the select bit.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst` or `mrst_i`, the outputs are: `cpu_halt_o`=0, `pclk_en_o`=1, `ext_clk_en_o`=1, `status_o`=2'b00, `intevt_o`=0, `wake_o`=0. The standby-select bit is cleared.
- R2: A `sleep_exec_i` strobe taken while the select bit is 0 gives the following from the next cycle: `cpu_halt_o`=1, `pclk_en_o`=1, `ext_clk_en_o`=1 and `status_o`=2'b10 (bit 1 is the first status pin, bit 0 the second).
- R3: While the block is halted with clocks running, `refresh_i`=1 forces `status_o` to 2'b00 in the same cycle. The status returns to 2'b10 when refresh drops.
- R4: A strobe taken while the select bit is 1, with no refresh in progress, gives the following from the next cycle: `cpu_halt_o`=1, `pclk_en_o`=0, `ext_clk_en_o`=0 and `status_o`=2'b11. `periph_rst_o` is high for exactly the first standby cycle.
- R5: If refresh is in progress on standby entry, the clocks stay enabled until the edge at which `refresh_i` is sampled low. They are gated from the cycle after that edge.
- R6: In sleep, any bit of `irq_i` high at an edge releases the halt in the next cycle. `wake_o` pulses for one cycle. No interrupt mask is consulted.
- R7: The event code for source index i is EVT_BASE + i*EVT_STEP, truncated to EVT_W bits. It is loaded into `intevt_o` on the waking edge and held until the next wake or reset.
- R8: When several sources are pending together, the lowest index wins. Index 0 is the non-maskable source.
- R9: In standby, an interrupt re-enables both clocks from the next cycle. `cpu_halt_o` stays 1 and `status_o` stays 11 for SETTLE_CYC cycles. The halt then drops and `wake_o` pulses.
- R10: `mrst_i` taken in sleep or standby returns all outputs to the R1 values in the next cycle, without a `wake_o` pulse.
- R11: `stby_we_i` loads `stby_wd_i` into the select bit. A strobe on the same edge uses the value held before that write.
- R12: `irq_i` in the run state has no effect: `intevt_o` keeps its value and `wake_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| mrst_i | input | 1 | Manual reset, synchronous, active high |
| sleep_exec_i | input | 1 | One-cycle strobe from the sleep instruction |
| stby_we_i | input | 1 | Write strobe for the standby-select bit |
| stby_wd_i | input | 1 | Value written into the standby-select bit |
| refresh_i | input | 1 | Memory refresh cycle in progress |
| irq_i | input | NSRC | Interrupt requests; index 0 is the non-maskable source |
| cpu_halt_o | output | 1 | Halts CPU instruction flow; CPU state is kept |
| pclk_en_o | output | 1 | Internal and peripheral clock enable |
| ext_clk_en_o | output | 1 | External clock output enable |
| periph_rst_o | output | 1 | One-cycle initialization pulse on standby entry |
| status_o | output | 2 | Mode status pins |
| intevt_o | output | EVT_W | Event code of the last waking interrupt |
| wake_o | output | 1 | One-cycle pulse that starts interrupt exception handling |

## Verification
The bench targets these corner cases:
- A refresh cycle still running when standby is requested. A design that gates clocks too early would drop `pclk_en_o` while `refresh_i` is high.
- The settle window. An off-by-one counter would release the halt one cycle early or late.
- Several interrupts pending at once. A wrong priority order would load the wrong event code.
- A manual reset from a low-power state, which must not emit a wake pulse.
- A select-bit write on the same edge as the sleep strobe.
- Interrupts arriving while the CPU is running, which a careless design would latch as a wake event.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STBY_WAIT,
        ST_STBY,
        ST_SETTLE
    } lpm_state_e;

    typedef struct packed {
        logic       halt;
        logic       pclk_en;
        logic       ext_en;
        logic [1:0] status;
    } lpm_out_t;

    localparam logic [1:0] STAT_RUN     = 2'b00;
    localparam logic [1:0] STAT_SLEEP   = 2'b10;
    localparam logic [1:0] STAT_REFRESH = 2'b00;
    localparam logic [1:0] STAT_STBY    = 2'b11;

    function automatic lpm_out_t decode_out(lpm_state_e st, logic refresh);
        lpm_out_t o;
        o = '{halt: 1'b0, pclk_en: 1'b1, ext_en: 1'b1, status: STAT_RUN};
        case (st)
            ST_RUN: ;
            ST_SLEEP, ST_STBY_WAIT: begin
                o.halt   = 1'b1;
                o.status = refresh ? STAT_REFRESH : STAT_SLEEP;
            end
            ST_STBY: begin
                o.halt    = 1'b1;
                o.pclk_en = 1'b0;
                o.ext_en  = 1'b0;
                o.status  = STAT_STBY;
            end
            ST_SETTLE: begin
                o.halt   = 1'b1;
                o.status = STAT_STBY;
            end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lpm_irq_pick.sv
module lpm_irq_pick #(
    parameter int NSRC     = 4,
    parameter int EVT_W    = 12,
    parameter int EVT_BASE = 'h1C0,
    parameter int EVT_STEP = 'h20
) (
    input  logic [NSRC-1:0]  irq_i,
    output logic             any_o,
    output logic [EVT_W-1:0] code_o
);

    logic [EVT_W-1:0] code_tab [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_code
        assign code_tab[g] = EVT_W'(EVT_BASE + g * EVT_STEP);
    end

    always_comb begin
        any_o  = |irq_i;
        code_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (irq_i[i]) code_o = code_tab[i];
        end
    end

endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic done_o
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt <= '0;
        else if (run_i)    cnt <= cnt + 1'b1;
    end

    assign done_o = (cnt == CW'(SETTLE_CYC - 1));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NSRC       = 4,
    parameter int EVT_W      = 12,
    parameter int EVT_BASE   = 'h1C0,
    parameter int EVT_STEP   = 'h20,
    parameter int SETTLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mrst_i,
    input  logic             sleep_exec_i,
    input  logic             stby_we_i,
    input  logic             stby_wd_i,
    input  logic             refresh_i,
    input  logic [NSRC-1:0]  irq_i,
    output logic             cpu_halt_o,
    output logic             pclk_en_o,
    output logic             ext_clk_en_o,
    output logic             periph_rst_o,
    output logic [1:0]       status_o,
    output logic [EVT_W-1:0] intevt_o,
    output logic             wake_o
);

    lpm_state_e       state, nxt;
    logic             any_rst;
    logic             stby_bit;
    logic             irq_any;
    logic [EVT_W-1:0] irq_code;
    logic             settle_done;
    logic             enter_stby, wake_ev, capture;
    logic             prst_q, wake_q;
    lpm_out_t         outs;

    assign any_rst = rst | mrst_i;

    lpm_irq_pick #(
        .NSRC(NSRC), .EVT_W(EVT_W), .EVT_BASE(EVT_BASE), .EVT_STEP(EVT_STEP)
    ) u_pick (
        .irq_i (irq_i),
        .any_o (irq_any),
        .code_o(irq_code)
    );

    lpm_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst   (any_rst),
        .clr_i (state != ST_SETTLE),
        .run_i (state == ST_SETTLE),
        .done_o(settle_done)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:
                if (sleep_exec_i) begin
                    if (!stby_bit)      nxt = ST_SLEEP;
                    else if (refresh_i) nxt = ST_STBY_WAIT;
                    else                nxt = ST_STBY;
                end
            ST_SLEEP:     if (irq_any)     nxt = ST_RUN;
            ST_STBY_WAIT: if (!refresh_i)  nxt = ST_STBY;
            ST_STBY:      if (irq_any)     nxt = ST_SETTLE;
            ST_SETTLE:    if (settle_done) nxt = ST_RUN;
            default:                       nxt = ST_RUN;
        endcase
    end

    assign enter_stby = (state != ST_STBY) && (nxt == ST_STBY);
    assign wake_ev    = ((state == ST_SLEEP) && irq_any) ||
                        ((state == ST_SETTLE) && settle_done);
    assign capture    = ((state == ST_SLEEP) || (state == ST_STBY)) && irq_any;

    always_ff @(posedge clk) begin
        if (any_rst) begin
            state    <= ST_RUN;
            stby_bit <= 1'b0;
            prst_q   <= 1'b0;
            wake_q   <= 1'b0;
            intevt_o <= '0;
        end else begin
            state  <= nxt;
            prst_q <= enter_stby;
            wake_q <= wake_ev;
            if (stby_we_i) stby_bit <= stby_wd_i;
            if (capture)   intevt_o <= irq_code;
        end
    end

    assign outs         = decode_out(state, refresh_i);
    assign cpu_halt_o   = outs.halt;
    assign pclk_en_o    = outs.pclk_en;
    assign ext_clk_en_o = outs.ext_en;
    assign status_o     = outs.status;
    assign periph_rst_o = prst_q;
    assign wake_o       = wake_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int EVT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             mrst_i,
    input logic             refresh_i,
    input logic             cpu_halt_o,
    input logic             pclk_en_o,
    input logic             ext_clk_en_o,
    input logic             periph_rst_o,
    input logic [1:0]       status_o,
    input logic [EVT_W-1:0] intevt_o,
    input logic             wake_o
);

    AST_RUN_CLOCKS_ON: assert property (@(posedge clk) disable iff (rst)
        !cpu_halt_o |-> pclk_en_o && ext_clk_en_o && status_o == 2'b00); // R1

    AST_EXT_TRACKS_INT: assert property (@(posedge clk) disable iff (rst)
        !pclk_en_o |-> !ext_clk_en_o && status_o == 2'b11); // R4

    AST_PRST_IN_STBY: assert property (@(posedge clk) disable iff (rst)
        periph_rst_o |-> !pclk_en_o && cpu_halt_o); // R4

    AST_PRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        periph_rst_o |=> !periph_rst_o); // R4

    AST_NO_GATE_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
        $fell(pclk_en_o) |-> !$past(refresh_i)); // R5

    AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> !cpu_halt_o && $past(cpu_halt_o)); // R6

    AST_SETTLE_HALTED: assert property (@(posedge clk) disable iff (rst || mrst_i)
        $rose(pclk_en_o) && !$past(mrst_i) |-> cpu_halt_o && status_o == 2'b11); // R9

    AST_MRST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(mrst_i) |-> !cpu_halt_o && !wake_o && intevt_o == '0); // R10

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mrst_i      (mrst_i),
    .refresh_i   (refresh_i),
    .cpu_halt_o  (cpu_halt_o),
    .pclk_en_o   (pclk_en_o),
    .ext_clk_en_o(ext_clk_en_o),
    .periph_rst_o(periph_rst_o),
    .status_o    (status_o),
    .intevt_o    (intevt_o),
    .wake_o      (wake_o)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;

    localparam int NSRC  = 4;
    localparam int EVT_W = 12;
    localparam int BASE  = 'h1C0;
    localparam int STEP  = 'h20;
    localparam int SET   = 5;

    logic             clk = 1'b0;
    logic             rst, mrst_i, sleep_exec_i, stby_we_i, stby_wd_i, refresh_i;
    logic [NSRC-1:0]  irq_i;
    logic             cpu_halt_o, pclk_en_o, ext_clk_en_o, periph_rst_o, wake_o;
    logic [1:0]       status_o;
    logic [EVT_W-1:0] intevt_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(
        .NSRC(NSRC), .EVT_W(EVT_W), .EVT_BASE(BASE), .EVT_STEP(STEP), .SETTLE_CYC(SET)
    ) dut (
        .clk(clk), .rst(rst), .mrst_i(mrst_i), .sleep_exec_i(sleep_exec_i),
        .stby_we_i(stby_we_i), .stby_wd_i(stby_wd_i), .refresh_i(refresh_i),
        .irq_i(irq_i), .cpu_halt_o(cpu_halt_o), .pclk_en_o(pclk_en_o),
        .ext_clk_en_o(ext_clk_en_o), .periph_rst_o(periph_rst_o),
        .status_o(status_o), .intevt_o(intevt_o), .wake_o(wake_o)
    );

    function automatic int exp_pick(logic [NSRC-1:0] m);
        for (int i = 0; i < NSRC; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [EVT_W-1:0] exp_code(int idx);
        return EVT_W'(BASE + idx * STEP);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_outs(string req, logic h, logic pc, logic ec, logic [1:0] st);
        check(req, "halt", 32'(cpu_halt_o), 32'(h));
        check(req, "pclk_en", 32'(pclk_en_o), 32'(pc));
        check(req, "ext_clk_en", 32'(ext_clk_en_o), 32'(ec));
        check(req, "status", 32'(status_o), 32'(st));
    endtask

    task automatic set_bit(logic v);
        stby_we_i = 1'b1; stby_wd_i = v; step(); stby_we_i = 1'b0;
    endtask

    task automatic sleep_wake(logic [NSRC-1:0] m, bit with_refresh);
        set_bit(1'b0);
        sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
        chk_outs("R2", 1, 1, 1, 2'b10);
        if (with_refresh) begin
            refresh_i = 1'b1; #1;
            check("R3", "status in refresh", 32'(status_o), 32'h0);
            step(); refresh_i = 1'b0; #1;
            check("R3", "status after refresh", 32'(status_o), 32'h2);
        end
        irq_i = m; step();
        check("R6", "halt released", 32'(cpu_halt_o), 0);
        check("R6", "wake pulse", 32'(wake_o), 1);
        check("R8", "intevt", 32'(intevt_o), 32'(exp_code(exp_pick(m))));
        irq_i = '0; step();
        check("R6", "wake one cycle", 32'(wake_o), 0);
    endtask

    task automatic stby_wake(logic [NSRC-1:0] m, int refr);
        set_bit(1'b1);
        refresh_i = (refr > 0);
        sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
        for (int i = 0; i < refr; i++) begin
            chk_outs("R5", 1, 1, 1, 2'b00);
            if (i < refr - 1) step();
        end
        refresh_i = 1'b0;
        if (refr > 0) step();
        chk_outs("R4", 1, 0, 0, 2'b11);
        check("R4", "periph_rst", 32'(periph_rst_o), 1);
        step();
        check("R4", "periph_rst one cycle", 32'(periph_rst_o), 0);
        check("R4", "pclk held off", 32'(pclk_en_o), 0);
        irq_i = m; step();
        chk_outs("R9", 1, 1, 1, 2'b11);
        for (int i = 1; i < SET; i++) begin
            step();
            check("R9", "halt during settle", 32'(cpu_halt_o), 1);
        end
        step();
        check("R9", "halt released", 32'(cpu_halt_o), 0);
        check("R9", "wake pulse", 32'(wake_o), 1);
        check("R7", "intevt", 32'(intevt_o), 32'(exp_code(exp_pick(m))));
        irq_i = '0; step();
        check("R9", "wake one cycle", 32'(wake_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [EVT_W-1:0] held;
        void'($urandom(32'd4711));
        rst = 1'b1; mrst_i = 1'b0; sleep_exec_i = 1'b0; stby_we_i = 1'b0;
        stby_wd_i = 1'b0; refresh_i = 1'b0; irq_i = '0;
        step(); step(); rst = 1'b0; step();
        chk_outs("R1", 0, 1, 1, 2'b00);
        check("R1", "intevt", 32'(intevt_o), 0);
        check("R1", "wake", 32'(wake_o), 0);

        // R7, R8: single sources and a multi-source pattern
        sleep_wake(4'b1000, 1);
        sleep_wake(4'b0110, 0);
        sleep_wake(4'b1111, 0);
        stby_wake(4'b0100, 0);
        stby_wake(4'b1010, 2);

        // R12: interrupts while running are ignored
        held = intevt_o;
        irq_i = 4'b0001; step(); step();
        check("R12", "intevt kept", 32'(intevt_o), 32'(held));
        check("R12", "no wake", 32'(wake_o), 0);
        irq_i = '0;

        // R10: manual reset from standby, then bit must read back cleared
        set_bit(1'b1);
        sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
        chk_outs("R10", 1, 0, 0, 2'b11);
        mrst_i = 1'b1; step(); mrst_i = 1'b0;
        chk_outs("R10", 0, 1, 1, 2'b00);
        check("R10", "no wake", 32'(wake_o), 0);
        check("R10", "intevt cleared", 32'(intevt_o), 0);
        sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
        chk_outs("R1", 1, 1, 1, 2'b10);
        mrst_i = 1'b1; step(); mrst_i = 1'b0;
        chk_outs("R10", 0, 1, 1, 2'b00);

        // R11: write on the same edge as the strobe uses the old value
        stby_we_i = 1'b1; stby_wd_i = 1'b1; sleep_exec_i = 1'b1; step();
        stby_we_i = 1'b0; sleep_exec_i = 1'b0;
        chk_outs("R11", 1, 1, 1, 2'b10);
        irq_i = 4'b0010; step(); irq_i = '0; step();
        sleep_exec_i = 1'b1; step(); sleep_exec_i = 1'b0;
        chk_outs("R11", 1, 0, 0, 2'b11);
        irq_i = 4'b0001; step(); irq_i = '0;
        repeat (SET + 1) step();

        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [NSRC-1:0] m;
            m = NSRC'($urandom_range(1, (1 << NSRC) - 1));
            if ($urandom_range(0, 1) == 0) sleep_wake(m, $urandom_range(0, 1) == 1);
            else                           stby_wake(m, $urandom_range(0, 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule